// File: doc/BRIEF.md
# Biased Four-Lane Byte Dot Product

This block is a purely combinational arithmetic unit. It multiplies two 32-bit words lane by lane and returns the sum. Each word is split into four byte lanes. Before a lane is multiplied, each byte is widened as signed or unsigned, as its operand's mode input selects. A per-operand 9-bit two's-complement offset is then added to it. The four lane products are added into one 32-bit result.

The unit is meant to be instantiated many times inside a convolution accumulator array. Each array cell feeds it one word of activations and one word of weights, together with the zero-point offsets and signedness of each tensor. The result appears in the same cycle as the inputs. There are no registers, no pipeline stages and no saturation.

Top module: `biased_dot4`

## Requirements
- R1: Lane k of each operand word is taken from bits 8k+7 down to 8k, and lane k of one operand is paired only with lane k of the other.
- R2: When `a_is_signed` is 1, each byte of `a_word` is sign-extended (0x80 reads as -128, 0xFF as -1). When it is 0, each byte is zero-extended (0x80 reads as 128, 0xFF as 255).
- R3: `b_is_signed` selects the byte interpretation of `b_word` in the same way as R2, independently of `a_is_signed`.
- R4: Each 9-bit offset is read as a two's-complement value in the range -256 to +255. The value 9'h100 is -256 and 9'h0FF is +255. It is added to every widened byte of its own operand before the multiply.
- R5: Each lane product is (a_byte + a_offset) × (b_byte + b_offset), computed as an exact signed product.
- R6: `dot_out` is the sum of the four lane products in 32-bit two's complement, so a negative sum appears with its upper bits set.
- R7: The output depends only on the present inputs and settles within the same cycle as they change. No state is kept from one input set to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_word | input | 32 | First operand, four byte lanes |
| b_word | input | 32 | Second operand, four byte lanes |
| a_offset | input | 9 | Two's-complement offset added to every byte of `a_word` |
| b_offset | input | 9 | Two's-complement offset added to every byte of `b_word` |
| a_is_signed | input | 1 | 1: bytes of `a_word` are signed; 0: unsigned |
| b_is_signed | input | 1 | 1: bytes of `b_word` are signed; 0: unsigned |
| dot_out | output | 32 | Sum of the four biased lane products |

## Verification
Whenever the inputs change, the embedded assertions check several properties. Each widened byte must be non-negative in unsigned mode and must lie within its mode's range. Each biased operand must lie within the range that a 10-bit signed multiplier can hold. A zero factor must give a zero lane product, and four zero products must give a zero sum. Only the bench scenarios can show that the numbers are right. Those scenarios cover lane ordering, the 0x80 and 0xFF bytes under all four signedness combinations, the offset extremes -256 and +255, negative sums in two's complement, and agreement with an independent reference on random words.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int LANES_DEF  = 4;
  localparam int LANE_W_DEF = 8;
  localparam int BIAS_W_DEF = 9;
  localparam int ACC_W_DEF  = 32;

  // width of a biased operand: widened byte and offset, plus one carry bit
  function automatic int op_width(input int lane_w, input int bias_w);
    int w;
    w = (lane_w + 1 > bias_w) ? lane_w + 1 : bias_w;
    return w + 1;
  endfunction
endpackage

// File: rtl/bdp_lane_prep.sv
module bdp_lane_prep #(
  parameter int LANE_W = 8,
  parameter int BIAS_W = 9,
  parameter int OP_W   = 10
) (
  input  logic [LANE_W-1:0]      byte_in,
  input  logic                   sign_en,
  input  logic [BIAS_W-1:0]      bias_in,
  output logic signed [OP_W-1:0] op_out
);
  localparam int XB_W = LANE_W + 1;

  logic signed [XB_W-1:0] wide_byte;
  logic signed [OP_W-1:0] wide_byte_op;
  logic signed [OP_W-1:0] wide_bias;

  // widen the byte according to its mode
  always_comb begin
    if (sign_en) wide_byte = {byte_in[LANE_W-1], byte_in};
    else         wide_byte = {1'b0, byte_in};
  end

  always_comb begin
    wide_byte_op = {{(OP_W-XB_W){wide_byte[XB_W-1]}}, wide_byte};
    wide_bias    = {{(OP_W-BIAS_W){bias_in[BIAS_W-1]}}, bias_in};
    op_out       = wide_byte_op + wide_bias;
  end

  // unsigned bytes never widen to a negative value
  always_comb begin
    if (!sign_en)
      assert_unsigned_nonneg_R2: assert (wide_byte[XB_W-1] == 1'b0)
        else $error("unsigned byte widened negative");
  end

  // signed bytes keep the byte's own top bit as the sign
  always_comb begin
    if (sign_en)
      assert_signed_keeps_msb_R3: assert (wide_byte[XB_W-1] == byte_in[LANE_W-1])
        else $error("signed byte lost its sign");
  end
endmodule

// File: rtl/bdp_lane_mul.sv
module bdp_lane_mul #(
  parameter int OP_W  = 10,
  parameter int ACC_W = 32
) (
  input  logic signed [OP_W-1:0] op_a,
  input  logic signed [OP_W-1:0] op_b,
  output logic [ACC_W-1:0]       prod_out
);
  localparam int PR_W = 2 * OP_W;

  logic signed [PR_W-1:0] prod_n;

  always_comb begin
    prod_n   = op_a * op_b;
    prod_out = {{(ACC_W-PR_W){prod_n[PR_W-1]}}, prod_n};
  end

  // a zero factor must yield a zero product
  always_comb begin
    if (op_a == '0 || op_b == '0)
      assert_zero_factor_R5: assert (prod_out == '0)
        else $error("nonzero product from a zero factor");
  end

  // the widened product keeps a consistent sign in its upper bits
  always_comb begin
    assert_prod_sext_R6: assert (prod_out[ACC_W-1] == prod_n[PR_W-1])
      else $error("product sign lost in widening");
  end
endmodule

// File: rtl/bdp_sum.sv
module bdp_sum #(
  parameter int LANES = 4,
  parameter int ACC_W = 32
) (
  input  logic [LANES-1:0][ACC_W-1:0] prods,
  output logic [ACC_W-1:0]            total
);
  always_comb begin
    total = '0;
    for (int k = 0; k < LANES; k++) total = total + prods[k];
  end

  // four zero products must sum to zero
  always_comb begin
    if (prods == '0)
      assert_zero_sum_R6: assert (total == '0)
        else $error("nonzero sum of zero products");
  end
endmodule

// File: rtl/biased_dot4.sv
module biased_dot4
  import bdp_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  parameter int BIAS_W = BIAS_W_DEF,
  parameter int ACC_W  = ACC_W_DEF
) (
  input  logic [LANES*LANE_W-1:0] a_word,
  input  logic [LANES*LANE_W-1:0] b_word,
  input  logic [BIAS_W-1:0]       a_offset,
  input  logic [BIAS_W-1:0]       b_offset,
  input  logic                    a_is_signed,
  input  logic                    b_is_signed,
  output logic [ACC_W-1:0]        dot_out
);
  localparam int OP_W = op_width(LANE_W, BIAS_W);
  // bounds of a biased operand: lowest signed byte plus lowest offset,
  // highest unsigned byte plus highest offset
  localparam int OP_MIN = -(1 << (LANE_W-1)) - (1 << (BIAS_W-1));
  localparam int OP_MAX = ((1 << LANE_W) - 1) + ((1 << (BIAS_W-1)) - 1);

  logic signed [OP_W-1:0]       op_a [LANES];
  logic signed [OP_W-1:0]       op_b [LANES];
  logic [LANES-1:0][ACC_W-1:0]  lane_prod;

  // R1: lane k sits at bits 8k+7..8k and pairs with the same lane
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bdp_lane_prep #(.LANE_W(LANE_W), .BIAS_W(BIAS_W), .OP_W(OP_W)) u_prep_a (
      .byte_in (a_word[k*LANE_W +: LANE_W]),
      .sign_en (a_is_signed),
      .bias_in (a_offset),
      .op_out  (op_a[k])
    );
    bdp_lane_prep #(.LANE_W(LANE_W), .BIAS_W(BIAS_W), .OP_W(OP_W)) u_prep_b (
      .byte_in (b_word[k*LANE_W +: LANE_W]),
      .sign_en (b_is_signed),
      .bias_in (b_offset),
      .op_out  (op_b[k])
    );
    bdp_lane_mul #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mul (
      .op_a     (op_a[k]),
      .op_b     (op_b[k]),
      .prod_out (lane_prod[k])
    );

    // biased operands stay inside the range the multiplier is sized for
    always_comb begin
      assert_op_range_R4: assert (int'(op_a[k]) >= OP_MIN && int'(op_a[k]) <= OP_MAX &&
                                  int'(op_b[k]) >= OP_MIN && int'(op_b[k]) <= OP_MAX)
        else $error("biased operand out of range");
    end
  end

  // R7: purely combinational path to the output
  bdp_sum #(.LANES(LANES), .ACC_W(ACC_W)) u_sum (
    .prods (lane_prod),
    .total (dot_out)
  );
endmodule

// File: tb/sim_biased_dot4.sv
module sim_biased_dot4;
  logic        clk;
  logic        rst_n;
  logic [31:0] a_word, b_word;
  logic [8:0]  a_offset, b_offset;
  logic        a_is_signed, b_is_signed;
  logic [31:0] dot_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  biased_dot4 u0 (
    .a_word(a_word), .b_word(b_word),
    .a_offset(a_offset), .b_offset(b_offset),
    .a_is_signed(a_is_signed), .b_is_signed(b_is_signed),
    .dot_out(dot_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk; // 125 MHz

  // stimulus: a, b, a_off, b_off, a_sgn, b_sgn, expected, requirement
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic [8:0]  ao;
    logic [8:0]  bo;
    logic        asg;
    logic        bsg;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h00000000, 32'h00000000, 9'h000, 9'h000, 1'b0, 1'b0, 32'h00000000, 8'd7},
    '{32'h01010101, 32'h02020202, 9'h000, 9'h000, 1'b0, 1'b0, 32'h00000008, 8'd5},
    '{32'h04030201, 32'h01000000, 9'h000, 9'h000, 1'b0, 1'b0, 32'h00000004, 8'd1},
    '{32'h000000FF, 32'h000000FF, 9'h000, 9'h000, 1'b0, 1'b0, 32'h0000FE01, 8'd2},
    '{32'h000000FF, 32'h000000FF, 9'h000, 9'h000, 1'b1, 1'b1, 32'h00000001, 8'd3},
    '{32'h80808080, 32'h80808080, 9'h000, 9'h000, 1'b1, 1'b1, 32'h00010000, 8'd2},
    '{32'h80808080, 32'hFFFFFFFF, 9'h0FF, 9'h0FF, 1'b0, 1'b0, 32'h000BEC08, 8'd4},
    '{32'h00000000, 32'h00000000, 9'h100, 9'h100, 1'b1, 1'b1, 32'h00040000, 8'd4},
    '{32'h80808080, 32'hFFFFFFFF, 9'h100, 9'h0FF, 1'b1, 1'b0, 32'hFFF40C00, 8'd6}
  };

  function automatic logic [31:0] ref_dot(input logic [31:0] a, input logic [31:0] b,
                                          input logic [8:0] ao, input logic [8:0] bo,
                                          input logic asg, input logic bsg);
    int acc = 0;
    for (int k = 0; k < 4; k++) begin
      int av = asg ? int'($signed(a[8*k +: 8])) : int'({24'd0, a[8*k +: 8]});
      int bv = bsg ? int'($signed(b[8*k +: 8])) : int'({24'd0, b[8*k +: 8]});
      av = av + int'($signed(ao));
      bv = bv + int'($signed(bo));
      acc = acc + av * bv;
    end
    return acc;
  endfunction

  task automatic apply_check(input logic [31:0] a, input logic [31:0] b,
                             input logic [8:0] ao, input logic [8:0] bo,
                             input logic asg, input logic bsg,
                             input logic [31:0] exp, input string req);
    @(posedge clk);
    a_word = a; b_word = b; a_offset = ao; b_offset = bo;
    a_is_signed = asg; b_is_signed = bsg;
    @(negedge clk);
    checks++;
    if (dot_out !== exp) begin
      errors++;
      $display("FAIL %s a=%h b=%h ao=%h bo=%h sa=%b sb=%b actual=%h expected=%h",
               req, a, b, ao, bo, asg, bsg, dot_out, exp);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    a_word = '0; b_word = '0; a_offset = '0; b_offset = '0;
    a_is_signed = 1'b0; b_is_signed = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;

    // idle state with zero inputs (R7)
    @(negedge clk);
    checks++;
    if (dot_out !== 32'd0) begin
      errors++;
      $display("FAIL R7 idle actual=%h expected=%h", dot_out, 32'd0);
    end

    // table walk
    for (int i = 0; i < NV; i++)
      apply_check(VECS[i].a, VECS[i].b, VECS[i].ao, VECS[i].bo,
                  VECS[i].asg, VECS[i].bsg, VECS[i].exp,
                  $sformatf("R%0d vec%0d", VECS[i].req, i));

    // R2 R3: corner bytes and offsets in all four sign combinations
    for (int m = 0; m < 4; m++) begin
      logic sa = m[0];
      logic sb = m[1];
      apply_check(32'hFF80FF80, 32'h80FF80FF, 9'h100, 9'h0FF, sa, sb,
                  ref_dot(32'hFF80FF80, 32'h80FF80FF, 9'h100, 9'h0FF, sa, sb), "R2_R3 corners");
      apply_check(32'h80FF0080, 32'hFF00FF80, 9'h0FF, 9'h100, sa, sb,
                  ref_dot(32'h80FF0080, 32'hFF00FF80, 9'h0FF, 9'h100, sa, sb), "R3_R4 corners");
    end

    // R1: each lane alone
    for (int k = 0; k < 4; k++) begin
      logic [31:0] aw = 32'h00000003 << (8 * k);
      logic [31:0] bw = 32'h00000005 << (8 * k);
      apply_check(aw, bw, 9'h000, 9'h000, 1'b0, 1'b0, 32'd15, "R1 single lane");
      apply_check(aw, 32'h05050505 & ~bw, 9'h000, 9'h000, 1'b0, 1'b0, 32'd0, "R1 lane mismatch");
    end

    // R7: back to zero after nonzero input, no carried state
    apply_check(32'd0, 32'd0, 9'h000, 9'h000, 1'b0, 1'b0, 32'd0, "R7 no state");

    // R5 R6: random vectors against the reference
    for (int n = 0; n < 300; n++) begin
      logic [31:0] ra = $urandom;
      logic [31:0] rb = $urandom;
      logic [8:0]  rao = 9'($urandom);
      logic [8:0]  rbo = 9'($urandom);
      logic        rsa = 1'($urandom);
      logic        rsb = 1'($urandom);
      apply_check(ra, rb, rao, rbo, rsa, rsb, ref_dot(ra, rb, rao, rbo, rsa, rsb), "R5_R6 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule